// File: doc/BRIEF.md
# Duplicated-to-Triplicated Fault Boundary

This block sits at the execute stage of a soft-error-protected pipeline. Upstream of it, every stage register exists in two copies. Downstream of it, every stage register exists in three copies. Before a data-bus transfer starts, faults only need to be detected. Once a transfer has started, they must be masked. The block compares the two incoming copies with two independent comparators. It withholds the data-bus request whenever the copies disagree and marks such an instruction as corrupted in all three control replicas.

The block fans the two copies out into three lanes. Copy 0 with its ALU result feeds lanes 0 and 2, and copy 1 with its ALU result feeds lane 1. In the following stage, the latched contents of lanes 0 and 1 are compared. A difference there, or a corrupted mark carried over, requests a restart. The restart is a one-cycle pulse that goes out with a flush and with the instruction's reset-point address. Each lane reads the triplicated registers through its own bitwise majority voter. A single upset in any one lane therefore never reaches the voted outputs.

Top module: `dup_tmr_boundary`

## Requirements
- R1: While reset is held and in the first cycle after it, restart, flush, the three corrupted flags and the three valid outputs are all low.
- R2: The execute-stage bundle is compared between copy 0 and copy 1. The bundle is valid, control, reset point, request enable, write enable, address and write data. Any difference drops bus_req in the same cycle.
- R3: bus_req is high in the same cycle when copy 0 is valid, copy 0 requests, the copies agree and no restart is active. bus_we, bus_addr and bus_wdata then equal the copy 0 fields.
- R4: An instruction whose execute-stage copies differ appears one cycle later with all three corrupted flags high, restart and flush high, and all three valid outputs low.
- R5: Copy 0 feeds lanes 0 and 2, and copy 1 feeds lane 1. If only the ALU results differ, the bus request still goes out. One cycle later, restart and all three corrupted flags rise, and every voted result equals the copy 0 ALU value.
- R6: restart lasts one cycle per corrupted instruction, and flush accompanies it. restart_addr carries the reset point of that instruction. The instruction then in the execute stage issues no bus request and is discarded, so its valid outputs stay low one cycle later.
- R7: Each lane holds the record {valid, control, reset point, result}, with the result in the low DW bits. The voters take a bitwise majority of three. A single-bit flip in the result of any one lane leaves all three voted results correct. A flip in lane 0 or lane 1 triggers restart, and a flip in lane 2 does not.
- R8: A corrupted mark set in only one lane is outvoted: no restart, no corrupted flag, and the instruction stays valid.
- R9: An instruction that is not valid never raises a corrupted flag or restart, even when its copies differ.
- R10: A clean valid instruction appears one cycle after the execute stage with its valid outputs high (3'b111), its ALU result and its control field on all three lanes, and no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid0 | input | 1 | Copy 0 instruction valid |
| ex_valid1 | input | 1 | Copy 1 instruction valid |
| ex_ctrl0 | input | CW | Copy 0 control field |
| ex_ctrl1 | input | CW | Copy 1 control field |
| ex_rp0 | input | AW | Copy 0 reset-point address |
| ex_rp1 | input | AW | Copy 1 reset-point address |
| ex_req0 | input | 1 | Copy 0 bus request enable |
| ex_req1 | input | 1 | Copy 1 bus request enable |
| ex_we0 | input | 1 | Copy 0 bus write enable |
| ex_we1 | input | 1 | Copy 1 bus write enable |
| ex_addr0 | input | AW | Copy 0 bus address |
| ex_addr1 | input | AW | Copy 1 bus address |
| ex_wdata0 | input | DW | Copy 0 bus write data |
| ex_wdata1 | input | DW | Copy 1 bus write data |
| alu_res0 | input | DW | ALU result from copy 0 |
| alu_res1 | input | DW | ALU result from copy 1 |
| bus_req | output | 1 | Data-bus request |
| bus_we | output | 1 | Data-bus write enable |
| bus_addr | output | AW | Data-bus address |
| bus_wdata | output | DW | Data-bus write data |
| ma_corrupt | output | 3 | Per-lane corrupted-instruction flag |
| ma_valid | output | 3 | Per-lane voted valid, low for corrupted instructions |
| ma_ctrl | output | 3*CW | Per-lane voted control field |
| ma_res | output | 3*DW | Per-lane voted result |
| restart | output | 1 | Restart request pulse |
| flush | output | 1 | Pipeline flush indication |
| restart_addr | output | AW | Address to restart from |

## Verification
The bus outputs are combinational on the execute-stage inputs. The bench drives each vector on the falling edge and samples the bus one nanosecond later, within the same cycle. The stage-after outputs pass through one register: voted valid, corrupted flags, results, restart and restart address. They are sampled one nanosecond after the next rising edge. The bench also checks the execute-stage bus output of the vector that follows a corrupted one, because that vector coincides with the restart pulse. Fault injections overwrite the lane registers just after the edge that loaded them, and the voted outputs are sampled within that same cycle.

// File: rtl/dup_tmr_boundary.sv
module dup_tmr_boundary #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ex_valid0,
  input  logic                   ex_valid1,
  input  logic [CW-1:0]          ex_ctrl0,
  input  logic [CW-1:0]          ex_ctrl1,
  input  logic [AW-1:0]          ex_rp0,
  input  logic [AW-1:0]          ex_rp1,
  input  logic                   ex_req0,
  input  logic                   ex_req1,
  input  logic                   ex_we0,
  input  logic                   ex_we1,
  input  logic [AW-1:0]          ex_addr0,
  input  logic [AW-1:0]          ex_addr1,
  input  logic [DW-1:0]          ex_wdata0,
  input  logic [DW-1:0]          ex_wdata1,
  input  logic [DW-1:0]          alu_res0,
  input  logic [DW-1:0]          alu_res1,
  output logic                   bus_req,
  output logic                   bus_we,
  output logic [AW-1:0]          bus_addr,
  output logic [DW-1:0]          bus_wdata,
  output logic [2:0]             ma_corrupt,
  output logic [2:0]             ma_valid,
  output logic [2:0][CW-1:0]     ma_ctrl,
  output logic [2:0][DW-1:0]     ma_res,
  output logic                   restart,
  output logic                   flush,
  output logic [AW-1:0]          restart_addr
);
  localparam int BW    = 3 + CW + 2*AW + DW;
  localparam int RP_LO = DW;
  localparam int CT_LO = DW + AW;
  localparam int VB    = DW + AW + CW;
  localparam int LW    = VB + 1;

  function automatic logic [LW-1:0] maj3(input logic [LW-1:0] a, b, c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  wire [BW-1:0] bnd0 = {ex_valid0, ex_ctrl0, ex_rp0, ex_req0, ex_we0, ex_addr0, ex_wdata0};
  wire [BW-1:0] bnd1 = {ex_valid1, ex_ctrl1, ex_rp1, ex_req1, ex_we1, ex_addr1, ex_wdata1};

  logic cmp_a_mis, cmp_b_mis;
  assign cmp_a_mis = (bnd0 != bnd1);
  assign cmp_b_mis = |(bnd0 ^ bnd1);

  wire [LW-1:0] rec0 = {ex_valid0, ex_ctrl0, ex_rp0, alu_res0};
  wire [LW-1:0] rec1 = {ex_valid1, ex_ctrl1, ex_rp1, alu_res1};

  logic [2:0][LW-1:0] l_q;
  logic [2:0]         l_cor;
  logic [2:0][LW-1:0] v_rec;
  logic [2:0]         v_cor;
  logic [2:0]         lane_bad;
  logic               lane_diff;

  for (genvar i = 0; i < 3; i++) begin : g_lane
    wire [LW-1:0] src = (i == 1) ? rec1 : rec0;
    wire          cor_d = src[VB] & (cmp_a_mis | cmp_b_mis);

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        l_q[i]   <= '0;
        l_cor[i] <= 1'b0;
      end else begin
        l_q[i]   <= src;
        l_cor[i] <= cor_d;
      end
    end

    assign v_rec[i]      = maj3(l_q[0], l_q[1], l_q[2]);
    assign v_cor[i]      = (l_cor[0] & l_cor[1]) | (l_cor[0] & l_cor[2]) | (l_cor[1] & l_cor[2]);
    assign lane_bad[i]   = v_rec[i][VB] & (v_cor[i] | lane_diff);
    assign ma_corrupt[i] = lane_bad[i];
    assign ma_valid[i]   = v_rec[i][VB] & ~lane_bad[i];
    assign ma_ctrl[i]    = v_rec[i][CT_LO +: CW];
    assign ma_res[i]     = v_rec[i][DW-1:0];
  end

  assign lane_diff    = (l_q[0] != l_q[1]);
  assign restart      = (lane_bad[0] & lane_bad[1]) | (lane_bad[0] & lane_bad[2]) | (lane_bad[1] & lane_bad[2]);
  assign flush        = restart;
  assign restart_addr = v_rec[0][RP_LO +: AW];

  assign bus_req   = ex_valid0 & ex_req0 & ~(cmp_a_mis | cmp_b_mis) & ~restart;
  assign bus_we    = ex_we0;
  assign bus_addr  = ex_addr0;
  assign bus_wdata = ex_wdata0;

  a_r2_no_bus_on_ctrl_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_ctrl0 != ex_ctrl1) |-> !bus_req);

  a_r4_mismatch_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid0 && ex_valid1 && ex_ctrl0 != ex_ctrl1 && !restart) |=> (restart && ma_corrupt == 3'b111));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);

  a_r6_no_bus_while_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !bus_req);

  a_r5_result_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> (ma_res[1] == $past(alu_res0)));

  a_r9_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_valid0 && !ex_valid1) |=> (!restart && ma_corrupt == 3'b000));
endmodule

// File: tb/tb_dup_tmr_boundary.sv
module tb_dup_tmr_boundary;
  localparam int DW = 32, AW = 32, CW = 4;
  localparam int LW = DW + AW + CW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ex_valid0, ex_valid1, ex_req0, ex_req1, ex_we0, ex_we1;
  logic [CW-1:0] ex_ctrl0, ex_ctrl1;
  logic [AW-1:0] ex_rp0, ex_rp1, ex_addr0, ex_addr1;
  logic [DW-1:0] ex_wdata0, ex_wdata1, alu_res0, alu_res1;
  logic bus_req, bus_we, restart, flush;
  logic [AW-1:0] bus_addr, restart_addr;
  logic [DW-1:0] bus_wdata;
  logic [2:0] ma_corrupt, ma_valid;
  logic [2:0][CW-1:0] ma_ctrl;
  logic [2:0][DW-1:0] ma_res;

  int total = 0, fails = 0;
  bit done = 0;

  dup_tmr_boundary #(.DW(DW), .AW(AW), .CW(CW)) dut (.*);

  always #4 clk = ~clk;

  function automatic logic [CW-1:0] c_of(int i); return CW'(i) ^ 4'h5; endfunction
  function automatic logic [AW-1:0] rp_of(int i); return 32'h0000_1000 + AW'(i) * 4; endfunction
  function automatic logic [AW-1:0] ad_of(int i); return 32'h2000_0000 + AW'(i) * 16; endfunction
  function automatic logic [DW-1:0] wd_of(int i); return 32'hA5A5_0000 | DW'(i); endfunction
  function automatic logic [DW-1:0] alu_of(int i); return 32'h0000_0100 + DW'(i) * 7; endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input int i, input bit v, input bit en, input logic [CW-1:0] cx,
                       input bit wx, input logic [7:0] ax);
    ex_valid0 = v;        ex_valid1 = v;
    ex_ctrl0  = c_of(i);  ex_ctrl1  = c_of(i) ^ cx;
    ex_rp0    = rp_of(i); ex_rp1    = rp_of(i);
    ex_req0   = en;       ex_req1   = en;
    ex_we0    = i[0];     ex_we1    = i[0];
    ex_addr0  = ad_of(i); ex_addr1  = ad_of(i) ^ (wx ? 32'h8 : 32'h0);
    ex_wdata0 = wd_of(i); ex_wdata1 = wd_of(i);
    alu_res0  = alu_of(i); alu_res1 = alu_of(i) ^ DW'(ax);
  endtask

  // {v, en, cx[3:0], wx, ax[7:0], exp_bus, exp_restart, exp_valid}
  localparam logic [17:0] TBL [13] = '{
    {1'b1,1'b1,4'h0,1'b0,8'h00,1'b1,1'b0,1'b1},
    {1'b1,1'b0,4'h0,1'b0,8'h00,1'b0,1'b0,1'b1},
    {1'b1,1'b1,4'h1,1'b0,8'h00,1'b0,1'b1,1'b0},
    {1'b1,1'b1,4'h0,1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b1,1'b1,4'h0,1'b0,8'h80,1'b1,1'b1,1'b0},
    {1'b1,1'b0,4'h0,1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b0,1'b1,4'h0,1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b0,1'b1,4'h4,1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b1,1'b1,4'h0,1'b1,8'h00,1'b0,1'b1,1'b0},
    {1'b1,1'b1,4'h0,1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b1,1'b1,4'h8,1'b0,8'h01,1'b0,1'b1,1'b0},
    {1'b1,1'b1,4'h0,1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b1,1'b1,4'h0,1'b0,8'h00,1'b1,1'b0,1'b1}
  };

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    drive(0, 0, 0, '0, 0, 8'h00);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 restart in reset", restart, 0);
    chk("R1 valid in reset", ma_valid, 0);
    chk("R1 corrupt in reset", ma_corrupt, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 restart after reset", restart, 0);
    chk("R1 flush after reset", flush, 0);
    chk("R1 valid after reset", ma_valid, 0);

    for (int i = 0; i < 13; i++) begin
      logic [17:0] e;
      e = TBL[i];
      @(negedge clk);
      drive(i, e[17], e[16], e[15:12], e[11], e[10:3]);
      #1;
      chk($sformatf("R2 R3 R6 bus_req vec%0d", i), bus_req, e[2]);
      if (e[2]) begin
        chk("R3 bus_addr from copy 0", bus_addr, ad_of(i));
        chk("R3 bus_wdata from copy 0", bus_wdata, wd_of(i));
        chk("R3 bus_we from copy 0", bus_we, i[0]);
      end
      @(posedge clk); #1;
      chk($sformatf("R4 R5 R6 R9 restart vec%0d", i), restart, e[1]);
      chk($sformatf("R6 flush vec%0d", i), flush, e[1]);
      chk($sformatf("R4 R9 R10 valid vec%0d", i), ma_valid, e[0] ? 3'b111 : 3'b000);
      chk($sformatf("R4 R5 R9 corrupt vec%0d", i), ma_corrupt, e[1] ? 3'b111 : 3'b000);
      if (e[1]) chk("R6 restart_addr", restart_addr, rp_of(i));
      if (e[0] || e[10:3] != 0)
        for (int k = 0; k < 3; k++) chk($sformatf("R5 R10 result lane%0d", k), ma_res[k], alu_of(i));
      if (e[0])
        for (int k = 0; k < 3; k++) chk($sformatf("R10 ctrl lane%0d", k), ma_ctrl[k], c_of(i));
    end

    for (int k = 0; k < 3; k++) begin
      logic [LW-1:0] rec;
      logic [2:0][LW-1:0] lanes;
      int idx;
      idx = 20 + k;
      rec = {1'b1, c_of(idx), rp_of(idx), alu_of(idx)};
      @(negedge clk);
      drive(idx, 1, 0, '0, 0, 8'h00);
      @(posedge clk); #1;
      lanes = {rec, rec, rec};
      lanes[k][5 + 9*k] = ~lanes[k][5 + 9*k];
      force dut.l_q = lanes;
      #1;
      for (int j = 0; j < 3; j++) chk($sformatf("R7 voted result flip lane%0d out%0d", k, j), ma_res[j], alu_of(idx));
      chk($sformatf("R7 restart on flip lane%0d", k), restart, k != 2);
      release dut.l_q;
      @(negedge clk);
      drive(0, 0, 0, '0, 0, 8'h00);
      @(posedge clk);
    end

    for (int k = 0; k < 3; k++) begin
      int idx;
      idx = 30 + k;
      @(negedge clk);
      drive(idx, 1, 0, '0, 0, 8'h00);
      @(posedge clk); #1;
      force dut.l_cor = 3'b001 << k;
      #1;
      chk($sformatf("R8 no restart cor lane%0d", k), restart, 0);
      chk($sformatf("R8 corrupt masked lane%0d", k), ma_corrupt, 3'b000);
      chk($sformatf("R8 valid kept lane%0d", k), ma_valid, 3'b111);
      release dut.l_cor;
      @(negedge clk);
      drive(0, 0, 0, '0, 0, 8'h00);
      @(posedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule